// File: doc/BRIEF.md
# Wavetable Upload/Download DMA Engine

This block moves a run of sample bytes between a host-memory byte stream and a local wavetable memory. Software programs a start position (16-bit paragraph index plus a 4-bit byte extension), a control byte and a transfer length. It then sets the request bit in the control byte. The engine turns the start position into a local byte address and streams the bytes, one per accepted handshake. It reports the local address of every byte and optionally flips the sign bit of sample bytes on the way in.

A separate address mapping applies when the channel moves 16-bit samples. When the last byte has gone, the engine clears its request bit and moves the start position past the data. It can also latch an interrupt that a read of the control register returns and clears. The host DMA controller and both memories lie outside the block. The block sees them as one incoming and one outgoing valid/ready byte stream, and the `toSys` flag tells which memory is the source.

Top module: `wtdma_engine`

## Requirements
- R1: After reset the control, start and extension registers read 0, and `dmaReq`, `irq` and `outValid` are low.
- R2: Writing the control register (`regSel`=0) with bit 0 set raises `dmaReq`. Bytes flow only while a transfer is active, starting the cycle after the request is seen. `inReady` stays low while `outReady` is low.
- R3: With `wideChan` low, the first byte goes to local address start*16 + extension (20 bits), and each following byte to the next address, wrapping at 2^20.
- R4: With `wideChan` high, the base address is (off & 0xC0000) + 2*(off & 0x1FFF0), where off = start*16 + extension. Bytes then follow at consecutive addresses.
- R5: Control bit 1 set means local memory is the source: `toSys` is high and every byte passes unchanged.
- R6: With bit 1 clear and bit 7 set, on a narrow channel, every byte leaves with bit 7 inverted.
- R7: On a wide channel, even-numbered bytes (the low halves) pass unchanged when control bit 6 is set. All other bytes follow R6.
- R8: A transfer of length L moves L bytes on a narrow channel and 2L on a wide one. L = 0 completes at once with no byte.
- R9: At terminal count, control bit 0 and `dmaReq` fall. If control bit 5 is set, `irq` rises in the same cycle.
- R10: At terminal count the start register grows by L/16 (mod 2^16), and the extension becomes (extension + L) mod 16.
- R11: A control read returns the stored byte with bit 6 ORed with the pending interrupt and bit 2 ORed with `wideChan`. The read clears the pending interrupt and stored bits 6 and 2.
- R12: Register writes that arrive while a transfer is active are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (control read has side effects) |
| regSel | input | 2 | 0 control, 1 start position, 2 extension nibble |
| regWrData | input | START_W | Write data |
| regRdData | output | START_W | Read data, valid in the cycle of `regRdEn` |
| wideChan | input | 1 | High when the host channel moves 16-bit samples |
| xferLen | input | LEN_W | Transfer length in samples, latched at start |
| dmaReq | output | 1 | Control bit 0, the pending request |
| irq | output | 1 | Terminal-count interrupt pending |
| inValid | input | 1 | Source byte valid |
| inReady | output | 1 | Source byte accepted |
| inData | input | 8 | Source byte |
| outValid | output | 1 | Destination byte valid |
| outReady | input | 1 | Destination ready |
| outData | output | 8 | Destination byte after sign handling |
| localAddr | output | START_W+4 | Local memory byte address of the current byte |
| toSys | output | 1 | High when local memory is the source |

## Verification
The bench builds the engine with its default widths: a 16-bit start register, 16-bit lengths and a 20-bit local address. These widths put the top of local memory within reach, so a narrow transfer from start 0xFFFF, extension 0xF shows both the address wrap and the start-register wrap. They also let the wide mapping fold bits across the full 0x1FFF0 field. Lengths of 17 and 20 carry into the start register, and length 0 exercises the immediate completion.

// File: rtl/wtdma_pkg.sv
`timescale 1ns/1ps
package wtdma_pkg;
  // control byte bit positions (software decodes these)
  localparam int CB_REQ    = 0;
  localparam int CB_TOSYS  = 1;
  localparam int CB_WIDE   = 2;
  localparam int CB_IRQEN  = 5;
  localparam int CB_TCFLAG = 6;
  localparam int CB_LOWRAW = 6;
  localparam int CB_FLIP   = 7;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_START = 2'd1;
  localparam logic [1:0] SEL_EXT   = 2'd2;

  typedef struct packed {
    logic busy;
    logic toSys;
    logic flipMsb;
    logic lowPass;
    logic wide;
    logic hiByte;
  } xfer_strobe_t;
endpackage

// File: rtl/wtdma_ctrl.sv
`timescale 1ns/1ps
module wtdma_ctrl
  import wtdma_pkg::*;
#(
  parameter int START_W = 16,
  parameter int LEN_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [1:0]         regSel,
  input  logic [START_W-1:0] regWrData,
  output logic [START_W-1:0] regRdData,
  input  logic               wideChan,
  input  logic [LEN_W-1:0]   xferLen,
  input  logic               beat,
  output xfer_strobe_t       strobes,
  output logic [START_W-1:0] startPos,
  output logic [3:0]         extNib,
  output logic [LEN_W:0]     byteIdx,
  output logic               dmaReq,
  output logic               irq
);
  localparam int IDX_W = LEN_W + 1;

  logic [7:0]         ctrlQ;
  logic [START_W-1:0] startQ;
  logic [3:0]         extQ;
  logic               busyQ;
  logic               wideQ;
  logic               irqQ;
  logic [LEN_W-1:0]   lenQ;
  logic [IDX_W-1:0]   idxQ;
  logic [IDX_W-1:0]   totalQ;

  logic               ctrlRd;
  logic               launch;
  logic [IDX_W-1:0]   launchTotal;
  logic               lastBeat;
  logic               finish;
  logic [LEN_W-1:0]   finLen;
  logic [7:0]         rdCtrl;

  assign ctrlRd      = regRdEn && (regSel == SEL_CTRL);
  assign launch      = !busyQ && ctrlQ[CB_REQ];
  assign launchTotal = wideChan ? {xferLen, 1'b0} : {1'b0, xferLen};
  assign lastBeat    = busyQ && beat && ((idxQ + 1'b1) == totalQ);
  assign finish      = lastBeat || (launch && (launchTotal == '0));
  assign finLen      = busyQ ? lenQ : xferLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      startQ <= '0;
      extQ   <= '0;
      busyQ  <= 1'b0;
      wideQ  <= 1'b0;
      irqQ   <= 1'b0;
      lenQ   <= '0;
      idxQ   <= '0;
      totalQ <= '0;
    end else begin
      // configuration is frozen while bytes are moving
      if (regWrEn && !busyQ) begin
        case (regSel)
          SEL_CTRL:  ctrlQ  <= regWrData[7:0];
          SEL_START: startQ <= regWrData;
          SEL_EXT:   extQ   <= regWrData[3:0];
          default: ;
        endcase
      end
      if (ctrlRd) begin
        ctrlQ[CB_TCFLAG] <= 1'b0;
        ctrlQ[CB_WIDE]   <= 1'b0;
        irqQ             <= 1'b0;
      end
      if (launch && (launchTotal != '0)) begin
        busyQ  <= 1'b1;
        lenQ   <= xferLen;
        wideQ  <= wideChan;
        idxQ   <= '0;
        totalQ <= launchTotal;
      end
      if (busyQ && beat) idxQ <= idxQ + 1'b1;
      if (finish) begin
        busyQ         <= 1'b0;
        ctrlQ[CB_REQ] <= 1'b0;
        startQ        <= startQ + START_W'(finLen >> 4);
        extQ          <= extQ + finLen[3:0];
        if (ctrlQ[CB_IRQEN]) irqQ <= 1'b1;
      end
    end
  end

  always_comb begin
    rdCtrl = ctrlQ;
    rdCtrl[CB_TCFLAG] = ctrlQ[CB_TCFLAG] | irqQ;
    rdCtrl[CB_WIDE]   = ctrlQ[CB_WIDE] | wideChan;
    case (regSel)
      SEL_CTRL:  regRdData = START_W'(rdCtrl);
      SEL_START: regRdData = startQ;
      SEL_EXT:   regRdData = START_W'(extQ);
      default:   regRdData = '0;
    endcase
  end

  always_comb begin
    strobes.busy    = busyQ;
    strobes.toSys   = ctrlQ[CB_TOSYS];
    strobes.flipMsb = ctrlQ[CB_FLIP] && !ctrlQ[CB_TOSYS];
    strobes.lowPass = ctrlQ[CB_LOWRAW];
    strobes.wide    = wideQ;
    strobes.hiByte  = idxQ[0];
  end

  assign startPos = startQ;
  assign extNib   = extQ;
  assign byteIdx  = idxQ;
  assign dmaReq   = ctrlQ[CB_REQ];
  assign irq      = irqQ;
endmodule

// File: rtl/wtdma_path.sv
`timescale 1ns/1ps
module wtdma_path
  import wtdma_pkg::*;
#(
  parameter int START_W = 16,
  parameter int LEN_W   = 16
) (
  input  xfer_strobe_t         strobes,
  input  logic [START_W-1:0]   startPos,
  input  logic [3:0]           extNib,
  input  logic [LEN_W:0]       byteIdx,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [7:0]           inData,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [7:0]           outData,
  output logic [START_W+3:0]   localAddr,
  output logic                 toSys,
  output logic                 beat
);
  localparam int ADDR_W = START_W + 4;
  // top two bits kept, paragraph bits below them doubled for 16-bit channels
  localparam logic [ADDR_W-1:0] HI_MASK  = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] MID_MASK = {3'b000, {(ADDR_W-7){1'b1}}, 4'b0000};

  logic [ADDR_W-1:0] narrowOff;
  logic [ADDR_W-1:0] wideOff;
  logic [ADDR_W-1:0] baseAddr;
  logic              keepRaw;

  assign narrowOff = {startPos, extNib};
  assign wideOff   = (narrowOff & HI_MASK) + ((narrowOff & MID_MASK) << 1);
  assign baseAddr  = strobes.wide ? wideOff : narrowOff;
  assign localAddr = baseAddr + ADDR_W'(byteIdx);

  assign outValid = strobes.busy && inValid;
  assign inReady  = strobes.busy && outReady;
  assign beat     = strobes.busy && inValid && outReady;

  assign keepRaw = strobes.wide && !strobes.hiByte && strobes.lowPass;
  assign outData = (strobes.flipMsb && !keepRaw) ? (inData ^ 8'h80) : inData;
  assign toSys   = strobes.toSys;
endmodule

// File: rtl/wtdma_engine.sv
`timescale 1ns/1ps
module wtdma_engine
  import wtdma_pkg::*;
#(
  parameter int START_W = 16,
  parameter int LEN_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [1:0]         regSel,
  input  logic [START_W-1:0] regWrData,
  output logic [START_W-1:0] regRdData,
  input  logic               wideChan,
  input  logic [LEN_W-1:0]   xferLen,
  output logic               dmaReq,
  output logic               irq,
  input  logic               inValid,
  output logic               inReady,
  input  logic [7:0]         inData,
  output logic               outValid,
  input  logic               outReady,
  output logic [7:0]         outData,
  output logic [START_W+3:0] localAddr,
  output logic               toSys
);
  xfer_strobe_t       strobes;
  logic [START_W-1:0] startPos;
  logic [3:0]         extNib;
  logic [LEN_W:0]     byteIdx;
  logic               beat;

  wtdma_ctrl #(.START_W(START_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData),
    .wideChan(wideChan), .xferLen(xferLen), .beat(beat),
    .strobes(strobes), .startPos(startPos), .extNib(extNib),
    .byteIdx(byteIdx), .dmaReq(dmaReq), .irq(irq)
  );

  wtdma_path #(.START_W(START_W), .LEN_W(LEN_W)) u_path (
    .strobes(strobes), .startPos(startPos), .extNib(extNib), .byteIdx(byteIdx),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .localAddr(localAddr), .toSys(toSys), .beat(beat)
  );
endmodule

// File: rtl/wtdma_checker.sv
`timescale 1ns/1ps
module wtdma_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              regRdEn,
  input logic [1:0]        regSel,
  input logic              dmaReq,
  input logic              irq,
  input logic              outValid,
  input logic              outReady,
  input logic [7:0]        inData,
  input logic [7:0]        outData,
  input logic              toSys,
  input logic [ADDR_W-1:0] localAddr
);
  // R9: the interrupt only appears together with the request dropping
  assert_tc_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $fell(dmaReq));

  // R11: a control read with nothing in flight leaves no interrupt pending
  assert_rd_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regSel == 2'd0 && !dmaReq) |=> !irq);

  // R2: bytes flow only under an outstanding request
  assert_active_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> dmaReq);

  // R5: local-to-host bytes are never altered
  assert_sys_passthru_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && toSys) |-> (outData == inData));

  // R3: consecutive bytes of one transfer use consecutive addresses
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> (!outValid || localAddr == $past(localAddr) + 1'b1));
endmodule

bind wtdma_engine wtdma_checker #(.ADDR_W(START_W + 4)) u_chk (
  .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regSel(regSel),
  .dmaReq(dmaReq), .irq(irq), .outValid(outValid), .outReady(outReady),
  .inData(inData), .outData(outData), .toSys(toSys), .localAddr(localAddr)
);

// File: tb/sim_wtdma_engine.sv
`timescale 1ns/1ps
module sim_wtdma_engine;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn, regRdEn;
  logic [1:0]  regSel;
  logic [15:0] regWrData, regRdData;
  logic        wideChan;
  logic [15:0] xferLen;
  logic        dmaReq, irq;
  logic        inValid, inReady;
  logic [7:0]  inData;
  logic        outValid, outReady;
  logic [7:0]  outData;
  logic [19:0] localAddr;
  logic        toSys;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  wtdma_engine u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .wideChan(wideChan), .xferLen(xferLen), .dmaReq(dmaReq), .irq(irq),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .localAddr(localAddr), .toSys(toSys)
  );

  typedef struct packed {
    logic        wide;
    logic [7:0]  ctrl;
    logic [15:0] start;
    logic [3:0]  ext;
    logic [15:0] len;
    logic [7:0]  seed;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 8'h21, 16'h0100, 4'h3, 16'd5,  8'h10},  // narrow, interrupt
    '{1'b0, 8'h81, 16'hFFFF, 4'hF, 16'd20, 8'hF0},  // narrow flip, wrap
    '{1'b1, 8'hC1, 16'h1234, 4'h5, 16'd4,  8'h7E},  // wide flip, low raw
    '{1'b1, 8'h83, 16'hC001, 4'h0, 16'd3,  8'h80},  // wide, local to host
    '{1'b1, 8'hA1, 16'h8000, 4'h9, 16'd17, 8'h01}   // wide flip, interrupt
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [15:0] d);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [15:0] d);
    regSel = sel; regRdEn = 1'b1;
    #1 d = regRdData;
    @(posedge clk); @(negedge clk);
    regRdEn = 1'b0;
  endtask

  function automatic logic [19:0] expAddr(input logic wide, input logic [15:0] st,
                                          input logic [3:0] ex, input int i);
    logic [19:0] off;
    off = {st, ex};
    if (wide) off = (off & 20'hC0000) + ((off & 20'h1FFF0) << 1);
    return off + 20'(i);
  endfunction

  function automatic logic [7:0] expData(input logic [7:0] c, input logic wide,
                                         input int i, input logic [7:0] d);
    logic flip;
    flip = c[7] & ~c[1];
    if (wide && (i % 2 == 0) && c[6]) return d;
    return flip ? (d ^ 8'h80) : d;
  endfunction

  task automatic runVec(input vec_t v);
    int idx, cyc, total;
    logic [15:0] rd;
    logic [7:0]  ea, ed;
    logic [19:0] addrExp;
    string       dTag;
    wideChan = v.wide; xferLen = v.len; outReady = 1'b1; inValid = 1'b1;
    regWrite(2'd1, v.start);
    regWrite(2'd2, {12'h000, v.ext});
    regWrite(2'd0, {8'h00, v.ctrl});
    total = v.wide ? 2 * int'(v.len) : int'(v.len);
    idx = 0; cyc = 0;
    while (idx < total && cyc < 1000) begin
      inData = v.seed + 8'(idx);
      #1;
      if (outValid) begin
        addrExp = expAddr(v.wide, v.start, v.ext, idx);
        check(localAddr == addrExp, v.wide ? "R4" : "R3", "local address",
              32'(localAddr), 32'(addrExp));
        ed = expData(v.ctrl, v.wide, idx, inData);
        dTag = v.ctrl[1] ? "R5" : (v.wide ? "R7" : "R6");
        check(outData == ed, dTag, "byte value", 32'(outData), 32'(ed));
        check(toSys == v.ctrl[1], "R5", "direction flag", 32'(toSys), 32'(v.ctrl[1]));
        idx++;
      end
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    check(idx == total, "R8", "byte count", 32'(idx), 32'(total));
    #1;
    check(!outValid, "R8", "stream idle after last byte", 32'(outValid), 32'h0);
    check(!dmaReq, "R9", "request cleared", 32'(dmaReq), 32'h0);
    check(irq == v.ctrl[5], "R9", "interrupt", 32'(irq), 32'(v.ctrl[5]));
    regRead(2'd1, rd);
    check(rd == v.start + (v.len >> 4), "R10", "start advance", 32'(rd),
          32'(16'(v.start + (v.len >> 4))));
    regRead(2'd2, rd);
    ea = {4'h0, 4'(v.ext + v.len[3:0])};
    check(rd[7:0] == ea, "R10", "extension nibble", 32'(rd), 32'(ea));
    regRead(2'd0, rd);
    ea = (v.ctrl & 8'hFE) | {1'b0, v.ctrl[5], 3'b000, v.wide, 2'b00};
    check(rd[7:0] == ea, "R11", "first control read", 32'(rd), 32'(ea));
    check(!irq, "R11", "interrupt cleared by read", 32'(irq), 32'h0);
    regRead(2'd0, rd);
    ea = (v.ctrl & 8'hBA) | {5'b00000, v.wide, 2'b00};
    check(rd[7:0] == ea, "R11", "second control read", 32'(rd), 32'(ea));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog all requirements: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    rstN = 1'b0; regWrEn = 1'b0; regRdEn = 1'b0; regSel = 2'd0; regWrData = '0;
    wideChan = 1'b0; xferLen = '0; inValid = 1'b1; inData = 8'h00; outReady = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    check(!dmaReq, "R1", "dmaReq after reset", 32'(dmaReq), 32'h0);
    check(!irq, "R1", "irq after reset", 32'(irq), 32'h0);
    check(!outValid, "R1", "outValid after reset", 32'(outValid), 32'h0);
    regRead(2'd0, rd); check(rd == 16'h0, "R1", "control after reset", 32'(rd), 32'h0);
    regRead(2'd1, rd); check(rd == 16'h0, "R1", "start after reset", 32'(rd), 32'h0);
    regRead(2'd2, rd); check(rd == 16'h0, "R1", "ext after reset", 32'(rd), 32'h0);

    foreach (VECS[k]) runVec(VECS[k]);

    // R12 writes during an active transfer, with R2 backpressure
    wideChan = 1'b0; xferLen = 16'd2; outReady = 1'b0; inValid = 1'b1; inData = 8'h3C;
    regWrite(2'd1, 16'h0010);
    regWrite(2'd2, 16'h0000);
    regWrite(2'd0, 16'h0001);
    check(dmaReq, "R2", "request raised by control write", 32'(dmaReq), 32'h1);
    @(posedge clk); @(negedge clk); #1;
    check(outValid, "R2", "transfer active", 32'(outValid), 32'h1);
    check(!inReady, "R2", "no accept under backpressure", 32'(inReady), 32'h0);
    regWrite(2'd0, 16'h0080);
    regWrite(2'd1, 16'h5555);
    regWrite(2'd2, 16'h0007);
    outReady = 1'b1; #1;
    check(outData == 8'h3C, "R12", "flip write ignored, byte 0", 32'(outData), 32'h3C);
    check(localAddr == 20'h00100, "R12", "start write ignored", 32'(localAddr), 32'h00100);
    @(posedge clk); @(negedge clk); #1;
    check(outData == 8'h3C, "R12", "flip write ignored, byte 1", 32'(outData), 32'h3C);
    @(posedge clk); @(negedge clk); #1;
    check(!dmaReq, "R9", "request cleared after stall run", 32'(dmaReq), 32'h0);
    regRead(2'd1, rd); check(rd == 16'h0010, "R12", "start kept", 32'(rd), 32'h0010);
    regRead(2'd2, rd); check(rd == 16'h0002, "R12", "ext kept then advanced", 32'(rd), 32'h2);
    regRead(2'd0, rd); check(rd == 16'h0000, "R12", "control kept", 32'(rd), 32'h0);

    // R8 zero-length transfer completes at once
    xferLen = 16'd0;
    regWrite(2'd0, 16'h0021);
    #1 check(!outValid, "R8", "no byte for zero length", 32'(outValid), 32'h0);
    @(posedge clk); @(negedge clk); #1;
    check(!outValid, "R8", "still no byte", 32'(outValid), 32'h0);
    check(!dmaReq, "R8", "zero length terminal count", 32'(dmaReq), 32'h0);
    check(irq, "R9", "interrupt on zero length", 32'(irq), 32'h1);
    regRead(2'd0, rd); check(rd == 16'h0060, "R11", "flag on read", 32'(rd), 32'h60);
    check(!irq, "R11", "cleared after read", 32'(irq), 32'h0);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule